// File: doc/BRIEF.md
# SMBus Telemetry Command Responder

This block is a bus target on a two-wire I2C/SMBus link that lets a system manager read measured currents, the block's own bus address and a one-byte status register, and write that status register. Both bus lines are sampled with the system clock, cleaned by a synchronizer and a majority filter, and decoded into start, stop and bit events. The target never stretches the clock. SDA is driven open-drain and appears as an output enable, where 1 pulls the line low.

The manager writes one command byte. On a following read, the target returns a frame. The frame starts with the command echoed, then carries the data bytes, and ends with a checksum byte that makes the byte sum of the whole frame zero modulo 256. The telemetry inputs are frozen into a snapshot at the moment the command byte is accepted, so every word within one frame comes from the same clock cycle. After reset, the 7-bit address is taken once from two active-low geographic pins, which must first be stable for a debounce window.

Top module: `smb_tlm_responder`

## Requirements
- R1: The target address is binary 01000, then the inverted level of `ga1_n_i`, then the inverted level of `ga0_n_i` (0x20 with both pins high, 0x22 with `ga1_n_i` low and `ga0_n_i` high). A matching address byte is ACKed. Any other address leaves SDA undriven for the rest of the transaction.
- R2: The geographic pins are latched once, after they have held the same value for `DEB_CYC` consecutive clocks following reset. Before the latch no address is ACKed. Pin changes after the latch have no effect until the next reset.
- R3: The SDA output enable changes only while SCL is low. The target pulls SDA low during the ninth clock to ACK.
- R4: After a write address, the command bytes 0x45, 0x55, 0x91 and 0x99 are ACKed. Any other command byte is NACKed and discards any earlier valid command.
- R5: A read returns the frame in this order: the command byte, the data bytes, then a checksum byte equal to minus the sum of all preceding frame bytes modulo 256. Every byte is sent MSB first. Every 16-bit word is sent with its high byte first.
- R6: Command 0x45 returns one data byte holding the latched address with bit 7 zero.
- R7: The status register resets to 0x18 and is visible on `status_o`. Command 0x55 read returns it as one data byte. Command 0x55 followed in the same write by one more byte stores that byte in the register and ACKs it.
- R8: Command 0x99 returns four 16-bit words from `cur_main_i`, lowest word (bits 15:0) first, giving eight data bytes.
- R9: Command 0x91 returns three 16-bit words from `cur_aux_i`, lowest word first, giving six data bytes.
- R10: The frame carries the input values present when the command byte was accepted. Later input changes do not alter it.
- R11: A read with no valid command pending, or a read beyond the end of the frame, returns 0xFF.
- R12: An SCL pulse that lasts a single clock sample is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| ga1_n_i | input | 1 | Geographic address pin, high bit, active low |
| ga0_n_i | input | 1 | Geographic address pin, low bit, active low |
| cur_main_i | input | 64 | Four main current words, 1 mA units, word k in bits 16k+15:16k |
| cur_aux_i | input | 48 | Three auxiliary current words, 1 mA units |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| status_o | output | 8 | Status register contents |

## Verification
The hardest condition to reach is a frame whose content would differ if the snapshot were taken late. The stimulus changes every current input between the ACK of the command byte and the repeated start of the read, then compares the returned words against the old values. A second awkward case is the window before the address latch: a transaction starts right after reset and must be NACKed even though its address matches. The glitch case injects a one-clock SCL pulse in the middle of a command byte, and the byte must still decode correctly.

// File: rtl/smb_tlm_pkg.sv
package smb_tlm_pkg;

    localparam int WORD_W     = 16;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int N_MAIN     = 4;
    localparam int N_AUX      = 3;
    localparam int MAX_DATA   = N_MAIN * WORD_BYTES;
    localparam int IDX_W      = $clog2(MAX_DATA + 3);
    localparam int DI_W       = $clog2(MAX_DATA);

    localparam logic [7:0] CMD_ADDR  = 8'h45;
    localparam logic [7:0] CMD_STAT  = 8'h55;
    localparam logic [7:0] CMD_AUXI  = 8'h91;
    localparam logic [7:0] CMD_MAINI = 8'h99;
    localparam logic [4:0] ADDR_BASE = 5'b01000;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic [7:0]               cmd;
        logic [N_MAIN*WORD_W-1:0] cur_main;
        logic [N_AUX*WORD_W-1:0]  cur_aux;
        logic [7:0]               stat;
    } snap_t;

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_ADDR) || (c == CMD_STAT) || (c == CMD_AUXI) || (c == CMD_MAINI);
    endfunction

    function automatic logic [IDX_W-1:0] data_len(input logic [7:0] c);
        case (c)
            CMD_ADDR, CMD_STAT: return IDX_W'(1);
            CMD_AUXI:           return IDX_W'(N_AUX * WORD_BYTES);
            CMD_MAINI:          return IDX_W'(N_MAIN * WORD_BYTES);
            default:            return '0;
        endcase
    endfunction

    function automatic logic [6:0] geo_addr(input logic g1_n, input logic g0_n);
        return {ADDR_BASE, ~g1_n, ~g0_n};
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [WIN-1:0]         win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
            line_o <= ($countones(win_q) > (WIN / 2));
        end
    end
endmodule

// File: rtl/smb_geo_latch.sv
module smb_geo_latch import smb_tlm_pkg::*; #(
    parameter int DEB_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ga1_n_i,
    input  logic       ga0_n_i,
    output logic [6:0] addr_o,
    output logic       done_o
);
    localparam int CNT_W = $clog2(DEB_CYC + 1);

    logic [1:0]       s1_q, s2_q, prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '1;
            s2_q   <= '1;
            prev_q <= '1;
            cnt_q  <= '0;
            done_o <= 1'b0;
            addr_o <= '0;
        end else begin
            s1_q   <= {ga1_n_i, ga0_n_i};
            s2_q   <= s1_q;
            prev_q <= s2_q;
            if (!done_o) begin
                if (s2_q != prev_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_W'(DEB_CYC - 1)) begin
                    done_o <= 1'b1;
                    addr_o <= geo_addr(s2_q[1], s2_q[0]);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(addr_o)));
endmodule

// File: rtl/smb_frame_builder.sv
module smb_frame_builder import smb_tlm_pkg::*; (
    input  snap_t            snap_i,
    input  logic             valid_i,
    input  logic [6:0]       addr_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    logic [7:0]       data [MAX_DATA];
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] di;
    logic [7:0]       csum;

    always_comb begin
        for (int i = 0; i < MAX_DATA; i++) data[i] = 8'h00;
        len = data_len(snap_i.cmd);
        case (snap_i.cmd)
            CMD_ADDR: data[0] = {1'b0, addr_i};
            CMD_STAT: data[0] = snap_i.stat;
            CMD_AUXI:
                for (int k = 0; k < N_AUX; k++)
                    for (int b = 0; b < WORD_BYTES; b++)
                        data[k*WORD_BYTES + b] =
                            snap_i.cur_aux[k*WORD_W + (WORD_BYTES-1-b)*8 +: 8];
            CMD_MAINI:
                for (int k = 0; k < N_MAIN; k++)
                    for (int b = 0; b < WORD_BYTES; b++)
                        data[k*WORD_BYTES + b] =
                            snap_i.cur_main[k*WORD_W + (WORD_BYTES-1-b)*8 +: 8];
            default: ;
        endcase
        csum = 8'h00 - snap_i.cmd;
        for (int i = 0; i < MAX_DATA; i++) csum = csum - data[i];
        di = idx_i - 1'b1;
        if (!valid_i)                   byte_o = 8'hFF;
        else if (idx_i == '0)           byte_o = snap_i.cmd;
        else if (idx_i <= len)          byte_o = data[di[DI_W-1:0]];
        else if (idx_i == len + 1'b1)   byte_o = csum;
        else                            byte_o = 8'hFF;
    end
endmodule

// File: rtl/smb_tlm_responder.sv
module smb_tlm_responder import smb_tlm_pkg::*; #(
    parameter int         DEB_CYC     = 1000,
    parameter logic [7:0] STATUS_INIT = 8'h18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     ga1_n_i,
    input  logic                     ga0_n_i,
    input  logic [N_MAIN*WORD_W-1:0] cur_main_i,
    input  logic [N_AUX*WORD_W-1:0]  cur_aux_i,
    output logic                     sda_oe_o,
    output logic [7:0]               status_o
);
    logic [1:0] raw, filt;
    logic       scl_f, sda_f, scl_p, sda_p;
    bus_evt_t   evt;

    assign raw = {scl_i, sda_i};
    for (genvar g = 0; g < 2; g++) begin : g_filt
        smb_line_filter u_filt (.clk(clk), .rst(rst), .line_i(raw[g]), .line_o(filt[g]));
    end
    assign scl_f = filt[1];
    assign sda_f = filt[0];

    always_comb begin
        evt.start = scl_f && scl_p && sda_p && !sda_f;
        evt.stop  = scl_f && scl_p && !sda_p && sda_f;
        evt.rise  = scl_f && !scl_p;
        evt.fall  = !scl_f && scl_p;
    end

    logic [6:0] my_addr;
    logic       addr_ok;

    smb_geo_latch #(.DEB_CYC(DEB_CYC)) u_geo (
        .clk(clk), .rst(rst), .ga1_n_i(ga1_n_i), .ga0_n_i(ga0_n_i),
        .addr_o(my_addr), .done_o(addr_ok));

    bus_st_e          st_q;
    logic [7:0]       sh_q, tx_byte;
    logic [2:0]       bit_q;
    logic             rx_full_q, is_addr_q, rw_q, valid_q, mnack_q;
    logic [1:0]       wr_cnt_q;
    logic [IDX_W-1:0] rd_idx_q;
    snap_t            snap_q;

    smb_frame_builder u_frame (
        .snap_i(snap_q), .valid_i(valid_q), .addr_i(my_addr),
        .idx_i(rd_idx_q), .byte_o(tx_byte));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;  sda_p <= 1'b1;
            st_q <= ST_IDLE; sh_q <= '0; bit_q <= '0;
            rx_full_q <= 1'b0; is_addr_q <= 1'b0; rw_q <= 1'b0;
            valid_q <= 1'b0; mnack_q <= 1'b0; wr_cnt_q <= '0;
            rd_idx_q <= '0; snap_q <= '0;
            sda_oe_o <= 1'b0; status_o <= STATUS_INIT;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
            if (evt.start) begin
                st_q <= ST_RX; is_addr_q <= 1'b1; bit_q <= '0;
                rx_full_q <= 1'b0; sda_oe_o <= 1'b0;
            end else if (evt.stop) begin
                st_q <= ST_IDLE; sda_oe_o <= 1'b0;
            end else begin
                case (st_q)
                    ST_RX: begin
                        if (evt.rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) rx_full_q <= 1'b1;
                        end else if (evt.fall && rx_full_q) begin
                            rx_full_q <= 1'b0;
                            bit_q     <= '0;
                            if (is_addr_q) begin
                                if (addr_ok && sh_q[7:1] == my_addr) begin
                                    sda_oe_o <= 1'b1; rw_q <= sh_q[0]; is_addr_q <= 1'b0;
                                    wr_cnt_q <= '0; rd_idx_q <= '0; st_q <= ST_ACK;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else if (wr_cnt_q == 2'd0) begin
                                if (cmd_known(sh_q)) begin
                                    valid_q         <= 1'b1;
                                    snap_q.cmd      <= sh_q;
                                    snap_q.cur_main <= cur_main_i;
                                    snap_q.cur_aux  <= cur_aux_i;
                                    snap_q.stat     <= status_o;
                                    sda_oe_o <= 1'b1; wr_cnt_q <= 2'd1; st_q <= ST_ACK;
                                end else begin
                                    valid_q <= 1'b0; st_q <= ST_IDLE;
                                end
                            end else if (wr_cnt_q == 2'd1 && valid_q && snap_q.cmd == CMD_STAT) begin
                                status_o <= sh_q;
                                sda_oe_o <= 1'b1; wr_cnt_q <= 2'd2; st_q <= ST_ACK;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (evt.fall) begin
                        if (rw_q) begin
                            sh_q <= tx_byte; sda_oe_o <= ~tx_byte[7];
                            bit_q <= '0; st_q <= ST_TX;
                            if (rd_idx_q != '1) rd_idx_q <= rd_idx_q + 1'b1;
                        end else begin
                            sda_oe_o <= 1'b0; st_q <= ST_RX;
                        end
                    end
                    ST_TX: if (evt.fall) begin
                        if (bit_q == 3'd7) begin
                            sda_oe_o <= 1'b0; st_q <= ST_MACK;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                            sda_oe_o <= ~sh_q[6];
                        end
                    end
                    ST_MACK: begin
                        if (evt.rise) begin
                            mnack_q <= sda_f;
                        end else if (evt.fall) begin
                            if (mnack_q) begin
                                st_q <= ST_IDLE;
                            end else begin
                                sh_q <= tx_byte; sda_oe_o <= ~tx_byte[7];
                                bit_q <= '0; st_q <= ST_TX;
                                if (rd_idx_q != '1) rd_idx_q <= rd_idx_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_f));

    assert_drive_phase_R3: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> (st_q == ST_ACK || st_q == ST_TX));

    assert_quiet_before_latch_R2: assert property (@(posedge clk) disable iff (rst)
        !addr_ok |-> !sda_oe_o);

    assert_status_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        (status_o != $past(status_o)) |-> ($past(st_q) == ST_RX && !$past(is_addr_q)));

endmodule

// File: tb/smb_tlm_responder_bench.sv
module smb_tlm_responder_bench;
    import smb_tlm_pkg::*;

    localparam int DEB = 1000;
    localparam int H   = 20;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic ga1_n = 1'b0, ga0_n = 1'b1;
    logic [N_MAIN*WORD_W-1:0] cur_main;
    logic [N_AUX*WORD_W-1:0]  cur_aux;
    logic sda_oe;
    logic [7:0] status;
    logic sda_line;

    int n_chk = 0, n_fail = 0, mon_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_tlm_responder #(.DEB_CYC(DEB)) u_smb_tlm_responder (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .ga1_n_i(ga1_n), .ga0_n_i(ga0_n), .cur_main_i(cur_main), .cur_aux_i(cur_aux),
        .sda_oe_o(sda_oe), .status_o(status));

    // R3 monitor: the target's drive may only move while SCL is low
    logic oe_q = 1'b0;
    always @(negedge clk) begin
        if (!rst && (sda_oe !== oe_q) && scl_m) begin
            mon_fail++;
            $display("FAIL R3 sda_oe moved with SCL high actual=%0b expected=%0b", sda_oe, oe_q);
        end
        oe_q <= sda_oe;
    end

    task automatic hw(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            chk("R3 monitor", mon_fail, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hw(Q); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hw(Q); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(Q);
            if (glitch && i == 4) begin scl_m = 1'b1; hw(1); scl_m = 1'b0; hw(Q); end
        end
        sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2); ack = (sda_line == 1'b0);
        hw(H/2); scl_m = 1'b0; hw(Q);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl_m = 1'b0; hw(Q);
        end
        sda_m = nack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(Q); sda_m = 1'b1;
    endtask

    // command write, then read of the frame (plus extra bytes past the end)
    task automatic t_frame(input string req, input logic [7:0] cmd, input int nd,
                           input logic [63:0] dvec, input bit glitch, input bit perturb,
                           input int extra);
        bit ack;
        logic [7:0] b, exp, sum;
        logic [N_MAIN*WORD_W-1:0] m_save;
        logic [N_AUX*WORD_W-1:0]  a_save;
        bus_start;
        send_byte(8'h44, 0, ack);  chk({req, " R1 addr ack"}, ack, 1);
        send_byte(cmd, glitch, ack); chk({req, " R4 cmd ack"}, ack, 1);
        m_save = cur_main; a_save = cur_aux;
        if (perturb) begin cur_main = ~cur_main; cur_aux = ~cur_aux; end
        bus_start;
        send_byte(8'h45, 0, ack);  chk({req, " R1 read addr ack"}, ack, 1);
        sum = 8'h00;
        for (int k = 0; k < nd + 2 + extra; k++) begin
            recv_byte(k == nd + 1 + extra, b);
            if (k == 0)            exp = cmd;
            else if (k <= nd)      exp = dvec[63 - 8*(k-1) -: 8];
            else if (k == nd + 1)  exp = 8'h00 - sum;
            else                   exp = 8'hFF;
            if (k <= nd) sum = sum + b;
            chk($sformatf("%s R5 byte %0d", req, k), b, exp);
        end
        bus_stop;
        cur_main = m_save; cur_aux = a_save;
    endtask

    task automatic t_reset;
        chk("R3 reset sda_oe", sda_oe, 0);
        chk("R7 reset status", status, 8'h18);
    endtask

    task automatic t_prelatch;
        bit ack;
        bus_start; send_byte(8'h44, 0, ack); bus_stop;
        chk("R2 no ack before latch", ack, 0);
    endtask

    task automatic t_no_cmd_read;
        bit ack; logic [7:0] b;
        bus_start; send_byte(8'h45, 0, ack); chk("R11 read addr ack", ack, 1);
        recv_byte(1, b); bus_stop;
        chk("R11 no command gives FF", b, 8'hFF);
    endtask

    task automatic t_addr_match;
        bit ack;
        bus_start; send_byte(8'h40, 0, ack); bus_stop; chk("R1 0x20 ignored", ack, 0);
        bus_start; send_byte(8'h46, 0, ack); bus_stop; chk("R1 0x23 ignored", ack, 0);
        bus_start; send_byte(8'h44, 0, ack); bus_stop; chk("R1 0x22 acked", ack, 1);
    endtask

    task automatic t_addr_frozen;
        bit ack;
        ga1_n = 1'b1; ga0_n = 1'b1; hw(2*DEB);
        bus_start; send_byte(8'h40, 0, ack); bus_stop; chk("R2 new pins ignored", ack, 0);
        bus_start; send_byte(8'h44, 0, ack); bus_stop; chk("R2 latched addr kept", ack, 1);
        ga1_n = 1'b0; ga0_n = 1'b1;
    endtask

    task automatic t_status_write;
        bit ack;
        bus_start;
        send_byte(8'h44, 0, ack);
        send_byte(8'h55, 0, ack); chk("R7 status cmd ack", ack, 1);
        send_byte(8'h3C, 0, ack); chk("R7 status data ack", ack, 1);
        bus_stop; hw(4);
        chk("R7 status written", status, 8'h3C);
    endtask

    task automatic t_unknown_cmd;
        bit ack; logic [7:0] b;
        bus_start;
        send_byte(8'h44, 0, ack);
        send_byte(8'h12, 0, ack); chk("R4 unknown cmd nacked", ack, 0);
        bus_start;
        send_byte(8'h45, 0, ack);
        recv_byte(1, b); bus_stop;
        chk("R11 invalidated read gives FF", b, 8'hFF);
    endtask

    initial begin
        hw(150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run;
    end

    initial begin
        cur_main = {16'h8001, 16'h0F0F, 16'hABCD, 16'h1234};
        cur_aux  = {16'hFFEE, 16'h0304, 16'h0102};
        hw(5); rst = 1'b0; hw(2);
        t_reset;
        t_prelatch;
        hw(DEB + 100);
        t_no_cmd_read;
        t_addr_match;
        t_frame("R6", 8'h45, 1, {8'h22, 56'h0}, 0, 0, 0);
        t_frame("R8", 8'h99, 8, 64'h1234_ABCD_0F0F_8001, 0, 0, 0);
        t_frame("R9", 8'h91, 6, {48'h0102_0304_FFEE, 16'h0}, 0, 0, 0);
        t_frame("R10", 8'h99, 8, 64'h1234_ABCD_0F0F_8001, 0, 1, 0);
        t_frame("R11 past end", 8'h45, 1, {8'h22, 56'h0}, 0, 0, 2);
        t_frame("R12 glitch", 8'h91, 6, {48'h0102_0304_FFEE, 16'h0}, 1, 0, 0);
        t_status_write;
        t_frame("R7 read", 8'h55, 1, {8'h3C, 56'h0}, 0, 0, 0);
        t_unknown_cmd;
        t_addr_frozen;
        finish_run;
    end
endmodule